// File: doc/BRIEF.md
# Dump-Load PWM Modulator with Minimum Pulse Width

This block produces the gate signal for one power FET that switches a rectified DC link into a resistive dump load. The demand it follows is the rectified sine magnitude. That demand passes only while the control loop holds the dump-enable high. It is first scaled by a trim word that caps the largest share of time the FET can be on. The scaled demand goes into a signed accumulator. The accumulator gives back one full-scale unit for every clock the output is high. The output is asked to go high while the accumulator sits at or above half-scale.

A separate timing stage turns that request into the real output edges. Every high interval and every low interval is held for at least `MIN_CYC` clocks, which is 200 clocks (4 µs) at a 50 MHz clock with 20 ns edge resolution. When an edge is held back, the demand behind it stays in the accumulator. It is then repaid through later, longer or extra pulses, so the average on-time still follows the demand.

Top module: `dump_pwm`

## Requirements
- R1: Synchronous active-low reset drives the output low, clears the accumulator and preloads the interval counter as already elapsed. With en=1, trim=all ones and mag=all ones, the output is low after the first clock following release and high after the second.
- R2: Every high interval that starts after reset lasts at least MIN_CYC clocks.
- R3: Every low interval that starts after reset lasts at least MIN_CYC clocks.
- R4: The scaled demand is floor(mag·trim / 2^TRIM_W). With trim = 0 the output never goes high.
- R5: The accumulator is signed and ACC_W = MAG_W + clog2(MIN_CYC+1) + 2 bits wide. Each clock with en=1 it adds the scaled demand and subtracts 2^MAG_W if the output is currently high, saturating at its signed limits. The output is requested high when en=1 and the accumulator is at least 2^(MAG_W-1).
- R6: When en is low, the accumulator clears on the next clock. A high output falls only once its minimum interval has completed, and it then stays low while en stays low.
- R7: Under constant demand, the number of high clocks over N clocks is N·scaled/2^MAG_W within a bound set by MIN_CYC, independent of the demand level.
- R8: The output changes at a clock edge only when the interval counter has reached MIN_CYC and the request differs from the output. The counter restarts at 1 on each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge-placement step per period |
| rst_n | input | 1 | Synchronous active-low reset |
| mag_i | input | MAG_W | Rectified sine magnitude, unsigned |
| dump_en_i | input | 1 | Dump enable from the control loop's threshold decision |
| trim_i | input | TRIM_W | Maximum-dump-power trim, scale factor trim/2^TRIM_W |
| pwm_o | output | 1 | Dump FET gate PWM |

## Verification
A corrupted accumulator or a wrong scale factor does not show up as one bad edge. It shows up as a shifted edge within a few demand periods, and as a drift in the long-run high count, which the duty checks measure over two thousand clocks. A wrong interval counter shows up at the very next edge, as an interval shorter or longer than the minimum. The bench therefore tracks every run length, and a cycle-by-cycle reference comparison flags the first clock where the output differs. Any fault in enable handling shows up within one minimum interval of the enable falling.

// File: rtl/dpwm_pkg.sv
// Package: shared helpers for the dump-load PWM.
// Assumes: width functions are only called at elaboration time.
package dpwm_pkg;

    // Bits needed to hold values 0..n inclusive.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Output level encoding, used for readability in the gate stage.
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } pwm_level_e;

endpackage

// File: rtl/dpwm_scale.sv
// Module: dpwm_scale
// Multiplies the magnitude by trim/2^TRIM_W with a shift-add chain (no
// multiplier) and drops the fractional bits.
// Assumes: purely combinational; trim is a plain unsigned fraction.
module dpwm_scale #(
    parameter int MAG_W  = 12,
    parameter int TRIM_W = 4
) (
    input  logic [MAG_W-1:0]  mag_i,
    input  logic [TRIM_W-1:0] trim_i,
    output logic [MAG_W-1:0]  scaled_o
);
    localparam int PROD_W = MAG_W + TRIM_W;

    logic [PROD_W-1:0] chain [TRIM_W+1];
    logic [PROD_W-1:0] mag_ext;

    assign mag_ext  = {{TRIM_W{1'b0}}, mag_i};
    assign chain[0] = '0;

    // One shifted partial product per trim bit, summed along the chain.
    for (genvar i = 0; i < TRIM_W; i++) begin : g_term
        assign chain[i+1] = chain[i] + (trim_i[i] ? (mag_ext << i) : '0);
    end

    // Drop the TRIM_W fractional bits; the result always fits MAG_W.
    assign scaled_o = MAG_W'(chain[TRIM_W] >> TRIM_W);
endmodule

// File: rtl/dpwm_accum.sv
// Module: dpwm_accum
// Signed demand accumulator. It adds the scaled demand each clock and takes
// away one full-scale unit for each clock the output is high. It requests
// high at or above half-scale. Demand held back by the gate stays stored as
// a positive balance; an enforced pulse beyond the demand leaves a debt.
// Assumes: pwm_i is the registered output of the gate stage.
module dpwm_accum #(
    parameter int MAG_W   = 12,
    parameter int MIN_CYC = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [MAG_W-1:0] dem_i,
    input  logic             pwm_i,
    output logic             req_o
);
    import dpwm_pkg::*;

    localparam int ACC_W = MAG_W + cnt_width(MIN_CYC) + 2;
    localparam logic signed [ACC_W:0]   FULL_S = {{(ACC_W-MAG_W){1'b0}}, 1'b1, {MAG_W{1'b0}}};
    localparam logic signed [ACC_W:0]   MAX_S  = {2'b00, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W:0]   MIN_S  = {2'b11, {(ACC_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] HALF_A = {{(ACC_W-MAG_W){1'b0}}, 1'b1, {(MAG_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] MAX_A  = {1'b0, {(ACC_W-1){1'b1}}};

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_nxt;
    logic signed [ACC_W:0]   ext_acc;
    logic signed [ACC_W:0]   ext_dem;
    logic signed [ACC_W:0]   sum;

    assign ext_acc = {acc_q[ACC_W-1], acc_q};
    assign ext_dem = {{(ACC_W-MAG_W+1){1'b0}}, dem_i};

    // Next balance: add demand, repay while high, saturate at signed limits.
    always_comb begin
        sum = ext_acc + ext_dem;
        if (pwm_i) begin
            sum = sum - FULL_S;
        end
        if (sum > MAX_S) begin
            acc_nxt = MAX_S[ACC_W-1:0];
        end else if (sum < MIN_S) begin
            acc_nxt = MIN_S[ACC_W-1:0];
        end else begin
            acc_nxt = sum[ACC_W-1:0];
        end
    end

    // Balance register: cleared by reset and whenever dumping is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (!en_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_nxt;
        end
    end

    // Request high only while enabled and the balance reaches half-scale.
    assign req_o = en_i && (acc_q >= HALF_A);

    // R6
    clear_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (acc_q == '0));

    // R5
    low_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !pwm_i && acc_q != MAX_A) |=> (acc_q >= $past(acc_q)));

    // R5
    high_repays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && pwm_i && acc_q >= HALF_A) |=> (acc_q < $past(acc_q)));
endmodule

// File: rtl/dpwm_mingate.sv
// Module: dpwm_mingate
// Turns the level request into output edges and holds every high and every
// low interval for at least MIN_CYC clocks. The interval counter restarts
// at 1 on each edge and saturates at MIN_CYC. Reset preloads it full, so the
// first pulse is not delayed.
// Assumes: req_i is a registered-path signal, stable for the whole clock.
module dpwm_mingate #(
    parameter int MIN_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pwm_o
);
    import dpwm_pkg::*;

    localparam int CNT_W = cnt_width(MIN_CYC);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MIN_CYC);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    pwm_level_e       lvl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             may_edge;

    assign may_edge = (cnt_q == CNT_FULL);

    // Level and interval counter: an edge only once the interval has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_LOW;
            cnt_q <= CNT_FULL;
        end else if (may_edge && (req_i != lvl_q)) begin
            lvl_q <= req_i ? LVL_HIGH : LVL_LOW;
            cnt_q <= CNT_ONE;
        end else if (!may_edge) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign pwm_o = (lvl_q == LVL_HIGH);

    // R2 R3
    edge_after_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_o != $past(pwm_o)) |-> ($past(cnt_q) == CNT_FULL));

    // R8
    rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> $past(req_i));

    // R8
    fall_needs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_o) |-> !$past(req_i));

    // R8
    restart_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_o != $past(pwm_o)) |-> (cnt_q == CNT_ONE));
endmodule

// File: rtl/dump_pwm.sv
// Module: dump_pwm (top)
// Dump-load PWM: trim scaling, then the demand accumulator, then the
// minimum-interval gate. The output is registered.
// Assumes: mag_i is an unsigned rectified sine sample and dump_en_i comes
// from the control loop's threshold decision, both synchronous to clk.
module dump_pwm #(
    parameter int MAG_W   = 12,
    parameter int TRIM_W  = 4,
    parameter int MIN_CYC = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAG_W-1:0]  mag_i,
    input  logic              dump_en_i,
    input  logic [TRIM_W-1:0] trim_i,
    output logic              pwm_o
);
    logic [MAG_W-1:0] scaled;
    logic             req;
    logic             pwm;

    dpwm_scale #(.MAG_W(MAG_W), .TRIM_W(TRIM_W)) u_scale (
        .mag_i    (mag_i),
        .trim_i   (trim_i),
        .scaled_o (scaled)
    );

    dpwm_accum #(.MAG_W(MAG_W), .MIN_CYC(MIN_CYC)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (dump_en_i),
        .dem_i (scaled),
        .pwm_i (pwm),
        .req_o (req)
    );

    dpwm_mingate #(.MIN_CYC(MIN_CYC)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .pwm_o (pwm)
    );

    assign pwm_o = pwm;

    // R4
    zero_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_i == '0) |-> (scaled == '0));

    // R6
    stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dump_en_i && !pwm_o) |=> !pwm_o);
endmodule

// File: tb/dump_pwm_tb.sv
// Bench: small configuration (6-bit magnitude, 3-bit trim, 8-clock minimum).
// It sweeps every trim value against a set of magnitudes and enable patterns,
// against a cycle-level reference computed from the requirement equations.
module dump_pwm_tb;
    localparam int MW    = 6;
    localparam int TW    = 3;
    localparam int MC    = 8;
    localparam int FULLV = 64;
    localparam int HALFV = 32;
    localparam int AMAX  = 2047;   // ACC_W = 6 + 4 + 2 = 12
    localparam int AMIN  = -2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [MW-1:0] mag = '0;
    logic          en = 1'b0;
    logic [TW-1:0] trim = '0;
    logic          pwm;

    int n_cmp = 0;
    int n_bad = 0;
    int m_acc = 0;
    int m_cnt = MC;
    bit m_out = 1'b0;
    bit prev_lvl = 1'b0;
    int run_len = 0;
    bit run_ok = 1'b0;
    int hi_short = 0;
    int lo_short = 0;
    int n_high = 0;

    dump_pwm #(.MAG_W(MW), .TRIM_W(TW), .MIN_CYC(MC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mag_i     (mag),
        .dump_en_i (en),
        .trim_i    (trim),
        .pwm_o     (pwm)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Reference step from R1, R4, R5, R6, R8 with the inputs now applied.
    task automatic model_step();
        int scaled, sum;
        bit req;
        if (!rst_n) begin
            m_acc = 0; m_out = 1'b0; m_cnt = MC;
        end else begin
            req    = en && (m_acc >= HALFV);
            scaled = (int'(mag) * int'(trim)) >> TW;
            if (!en) sum = 0;
            else begin
                sum = m_acc + scaled - (m_out ? FULLV : 0);
                if (sum > AMAX) sum = AMAX;
                if (sum < AMIN) sum = AMIN;
            end
            if (m_cnt == MC && req != m_out) begin
                m_out = req; m_cnt = 1;
            end else if (m_cnt < MC) begin
                m_cnt++;
            end
            m_acc = sum;
        end
    endtask

    // One clock: reference step, edge, compare at the falling edge, run tracking.
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(pwm === m_out, "R5/R8", int'(pwm), int'(m_out));
        if (pwm) n_high++;
        if (!rst_n) begin
            prev_lvl = 1'b0; run_len = 0; run_ok = 1'b0;
        end else if (pwm != prev_lvl) begin
            if (run_ok && run_len < MC) begin
                if (prev_lvl) hi_short++;
                else lo_short++;
            end
            run_ok = 1'b1; run_len = 1; prev_lvl = pwm;
        end else begin
            run_len++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
    endtask

    function automatic int mag_pick(input int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 9;
            3: return 32;
            4: return 45;
            default: return 63;
        endcase
    endfunction

    task automatic duty_check(input int t, input int m);
        int exp_hi, diff;
        do_reset();
        trim = TW'(t); mag = MW'(m); en = 1'b1;
        repeat (100) cyc();
        n_high = 0;
        repeat (2048) cyc();
        exp_hi = (2048 * ((m * t) >> TW)) / FULLV;
        diff = n_high - exp_hi;
        // R7: average on-time follows the scaled demand
        check(diff <= 24 && diff >= -24, "R7", n_high, exp_hi);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int hi_run;
        // R1: reset state and the first pulse starting at once
        do_reset();
        check(pwm == 1'b0, "R1", int'(pwm), 0);
        trim = '1; mag = '1; en = 1'b1;
        cyc();
        check(pwm == 1'b0, "R1", int'(pwm), 0);
        cyc();
        check(pwm == 1'b1, "R1", int'(pwm), 1);

        // Sweep: every trim value against a set of magnitudes and enable toggles
        for (int t = 0; t < (1 << TW); t++) begin
            for (int mi = 0; mi < 6; mi++) begin
                do_reset();
                hi_short = 0; lo_short = 0; n_high = 0;
                trim = TW'(t); mag = MW'(mag_pick(mi)); en = 1'b1;
                repeat (150) cyc();
                for (int k = 0; k < 6; k++) begin
                    en = ~en;
                    repeat (23 + k * 7) cyc();
                end
                check(hi_short == 0, "R2", hi_short, 0);
                check(lo_short == 0, "R3", lo_short, 0);
                if (t == 0) check(n_high == 0, "R4", n_high, 0);
            end
        end

        // Rectified-sine-like magnitude under a mid trim
        do_reset();
        hi_short = 0; lo_short = 0;
        trim = TW'(5); en = 1'b1;
        for (int k = 0; k < 600; k++) begin
            int tri_v;
            tri_v = ((k * 3) % 128) - 64;
            if (tri_v < 0) tri_v = -tri_v;
            if (tri_v > 63) tri_v = 63;
            mag = MW'(tri_v);
            cyc();
        end
        check(hi_short == 0, "R2", hi_short, 0);
        check(lo_short == 0, "R3", lo_short, 0);

        // R6: enable dropped early in a pulse; the pulse still lasts MC clocks
        do_reset();
        trim = '1; mag = '1; en = 1'b1;
        cyc();
        cyc();
        check(pwm == 1'b1, "R6", int'(pwm), 1);
        hi_run = 1;
        cyc(); hi_run += int'(pwm);
        cyc(); hi_run += int'(pwm);
        en = 1'b0;
        for (int k = 0; k < MC + 2; k++) begin
            cyc();
            if (pwm) hi_run++;
        end
        check(hi_run == MC, "R6", hi_run, MC);
        n_high = 0;
        repeat (40) cyc();
        check(n_high == 0, "R6", n_high, 0);

        // R7: long-run duty at three demand levels
        duty_check(7, 37);
        duty_check(2, 63);
        duty_check(7, 63);

        summary();
        $finish;
    end
endmodule